// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the register datapath of a small accumulator machine. It holds a 16-bit accumulator, a data register, two general registers, a program counter, an instruction register and a 12-bit memory address register. Every register both reads from and drives one shared internal bus. A source-select multiplexer chooses the single unit that drives the bus, so no tri-state enables are needed. A two-function arithmetic unit sits between the accumulator and the data register. Its result is one more bus source, and so is the read data coming back from memory.

The block decides nothing on its own. An external controller sequences every transfer. On each clock it presents a bus source code, any number of load strobes, a program counter increment, an accumulator complement and the arithmetic mode strobes. Memory is synchronous and external. The memory address register supplies the address. A write presents the current bus value as write data together with a write strobe that the memory captures on the clock. Read data is presented on its input while the controller selects the memory source.

Top module: `acc_datapath`

## Requirements
- R1: After reset, the accumulator, data register, both general registers, the program counter, the instruction register and the memory address register all hold zero.
- R2: The bus carries the source chosen by `bus_sel`. The codes are 0 accumulator, 1 data register, 2 general register 1, 3 general register 2, 4 program counter, 5 instruction register, 6 arithmetic result, 7 memory read data. `bus_o` shows the bus value in the same cycle.
- R3: With `alu_add` high, the arithmetic result is the accumulator plus the data register, modulo 2^16.
- R4: With only `alu_and` high, the arithmetic result is the bitwise AND of the accumulator and the data register.
- R5: With neither mode strobe high, the arithmetic result is zero. With both high, addition is performed.
- R6: With `cpl_acc` high, the accumulator takes its own bitwise inverse at the next clock. This happens without using the bus or the arithmetic unit, and it takes priority over `ld_acc`.
- R7: With `ld_mar` high, the memory address register captures bus bits 11:0 at the clock. Selecting the instruction register (code 5) therefore loads the operand address held in its low 12 bits. `mem_addr` always shows the memory address register.
- R8: With `inc_pc` high, the program counter advances by one at the clock and wraps from 0xFFFF to 0. If `ld_pc` is high in the same cycle, the bus value is loaded instead.
- R9: When several load strobes are high in one cycle, every selected register captures the same bus value.
- R10: A register whose load strobe is low keeps its value, whatever the bus carries and whatever the write strobe does.
- R11: The arithmetic result depends only on the accumulator and the data register. A general register affects it only after being copied into the data register.
- R12: `mem_wdata` equals the bus value and `mem_we` follows `wr_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 3 | Bus source code |
| ld_acc | input | 1 | Load accumulator from bus |
| ld_dr | input | 1 | Load data register from bus |
| ld_r1 | input | 1 | Load general register 1 from bus |
| ld_r2 | input | 1 | Load general register 2 from bus |
| ld_ir | input | 1 | Load instruction register from bus |
| ld_pc | input | 1 | Load program counter from bus |
| ld_mar | input | 1 | Load memory address register from bus bits 11:0 |
| inc_pc | input | 1 | Increment program counter |
| cpl_acc | input | 1 | Invert accumulator in place |
| alu_add | input | 1 | Arithmetic mode: addition |
| alu_and | input | 1 | Arithmetic mode: bitwise AND |
| wr_req | input | 1 | Memory write request |
| mem_rdata | input | 16 | Memory read data |
| bus_o | output | 16 | Current internal bus value |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |

## Verification
The hardest states to reach are those that need particular register contents: a carry out of bit 15 into the discarded bit, a program counter at 0xFFFF, or an instruction register whose upper bits must be dropped on the way to the address register. None of these registers can be written directly. The bench gets there by presenting a chosen word on the memory read input, selecting the memory source and pulsing the wanted load strobes. It then reads each register back by switching the bus source code. Priority cases such as complement against load, and load against increment, are driven as coincident strobes in one cycle.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  typedef enum logic [2:0] {
    SRC_ACC = 3'd0,
    SRC_DR  = 3'd1,
    SRC_R1  = 3'd2,
    SRC_R2  = 3'd3,
    SRC_PC  = 3'd4,
    SRC_IR  = 3'd5,
    SRC_ALU = 3'd6,
    SRC_MEM = 3'd7
  } bus_src_e;

  localparam int unsigned NUM_GP = 4;
  localparam int unsigned GP_DR  = 0;
  localparam int unsigned GP_R1  = 1;
  localparam int unsigned GP_R2  = 2;
  localparam int unsigned GP_IR  = 3;
endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/dp_acc.sv
module dp_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         cpl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] inv_fb;
  assign inv_fb = ~q;

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (cpl) q <= inv_fb;
    else if (ld)  q <= d;
  end
endmodule

// File: rtl/dp_pc.sv
module dp_pc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] step_up(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= d;
    else if (inc) q <= step_up(q);
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         add_en,
  input  logic         and_en,
  output logic [W-1:0] y
);
  function automatic logic [W-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] z);
    return x + z;
  endfunction

  function automatic logic [W-1:0] f_and(input logic [W-1:0] x, input logic [W-1:0] z);
    return x & z;
  endfunction

  always_comb begin
    if (add_en)      y = f_add(a, b);
    else if (and_en) y = f_and(a, b);
    else             y = '0;
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_sel,
  input  logic              ld_acc,
  input  logic              ld_dr,
  input  logic              ld_r1,
  input  logic              ld_r2,
  input  logic              ld_ir,
  input  logic              ld_pc,
  input  logic              ld_mar,
  input  logic              inc_pc,
  input  logic              cpl_acc,
  input  logic              alu_add,
  input  logic              alu_and,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bus_o,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);
  logic [DATA_W-1:0] bus_val;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] alu_y;
  logic [ADDR_W-1:0] mar_q;
  logic [NUM_GP-1:0] gp_ld;
  logic [DATA_W-1:0] gp_q [NUM_GP];
  logic [DATA_W-1:0] dr_q;
  logic [DATA_W-1:0] r1_q;

  assign gp_ld[GP_DR] = ld_dr;
  assign gp_ld[GP_R1] = ld_r1;
  assign gp_ld[GP_R2] = ld_r2;
  assign gp_ld[GP_IR] = ld_ir;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    dp_reg #(.W(DATA_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (gp_ld[g]),
      .d     (bus_val),
      .q     (gp_q[g])
    );
  end

  assign dr_q = gp_q[GP_DR];
  assign r1_q = gp_q[GP_R1];

  dp_acc #(.W(DATA_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld_acc),
    .cpl   (cpl_acc),
    .d     (bus_val),
    .q     (acc_q)
  );

  dp_pc #(.W(DATA_W)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld_pc),
    .inc   (inc_pc),
    .d     (bus_val),
    .q     (pc_q)
  );

  dp_reg #(.W(ADDR_W)) u_mar (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld_mar),
    .d     (bus_val[ADDR_W-1:0]),
    .q     (mar_q)
  );

  dp_alu #(.W(DATA_W)) u_alu (
    .a      (acc_q),
    .b      (dr_q),
    .add_en (alu_add),
    .and_en (alu_and),
    .y      (alu_y)
  );

  always_comb begin
    unique case (bus_src_e'(bus_sel))
      SRC_ACC: bus_val = acc_q;
      SRC_DR:  bus_val = dr_q;
      SRC_R1:  bus_val = r1_q;
      SRC_R2:  bus_val = gp_q[GP_R2];
      SRC_PC:  bus_val = pc_q;
      SRC_IR:  bus_val = gp_q[GP_IR];
      SRC_ALU: bus_val = alu_y;
      SRC_MEM: bus_val = mem_rdata;
      default: bus_val = '0;
    endcase
  end

  assign bus_o     = bus_val;
  assign mem_addr  = mar_q;
  assign mem_wdata = bus_val;
  assign mem_we    = wr_req;
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_sel,
  input logic              ld_acc,
  input logic              ld_r1,
  input logic              ld_pc,
  input logic              ld_mar,
  input logic              inc_pc,
  input logic              cpl_acc,
  input logic              alu_add,
  input logic              alu_and,
  input logic [DATA_W-1:0] bus_val,
  input logic [DATA_W-1:0] acc_q,
  input logic [DATA_W-1:0] dr_q,
  input logic [DATA_W-1:0] r1_q,
  input logic [DATA_W-1:0] pc_q,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r3_add_into_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_acc && !cpl_acc && bus_sel == 3'd6 && alu_add)
      |=> acc_q == DATA_W'($past(acc_q) + $past(dr_q)));

  a_r4_and_into_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_acc && !cpl_acc && bus_sel == 3'd6 && alu_and && !alu_add)
      |=> acc_q == ($past(acc_q) & $past(dr_q)));

  a_r6_complement: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_acc |=> acc_q == ~$past(acc_q));

  a_r7_mar_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mar |=> mem_addr == $past(bus_val[ADDR_W-1:0]));

  a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_pc && !ld_pc) |=> pc_q == DATA_W'($past(pc_q) + 1'b1));

  a_r10_r1_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_r1 |=> $stable(r1_q));
endmodule

bind acc_datapath dp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .ld_acc   (ld_acc),
  .ld_r1    (ld_r1),
  .ld_pc    (ld_pc),
  .ld_mar   (ld_mar),
  .inc_pc   (inc_pc),
  .cpl_acc  (cpl_acc),
  .alu_add  (alu_add),
  .alu_and  (alu_and),
  .bus_val  (bus_val),
  .acc_q    (acc_q),
  .dr_q     (dr_q),
  .r1_q     (r1_q),
  .pc_q     (pc_q),
  .mem_addr (mem_addr)
);

// File: tb/tb_acc_datapath.sv
`timescale 1ns/1ps
module tb_acc_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic        ld_acc = 0, ld_dr = 0, ld_r1 = 0, ld_r2 = 0, ld_ir = 0, ld_pc = 0, ld_mar = 0;
  logic        inc_pc = 0, cpl_acc = 0, alu_add = 0, alu_and = 0, wr_req = 0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] bus_o;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_datapath dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
    .ld_acc(ld_acc), .ld_dr(ld_dr), .ld_r1(ld_r1), .ld_r2(ld_r2), .ld_ir(ld_ir),
    .ld_pc(ld_pc), .ld_mar(ld_mar), .inc_pc(inc_pc), .cpl_acc(cpl_acc),
    .alu_add(alu_add), .alu_and(alu_and), .wr_req(wr_req), .mem_rdata(mem_rdata),
    .bus_o(bus_o), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobes_off();
    ld_acc = 0; ld_dr = 0; ld_r1 = 0; ld_r2 = 0; ld_ir = 0; ld_pc = 0; ld_mar = 0;
    inc_pc = 0; cpl_acc = 0; alu_add = 0; alu_and = 0; wr_req = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    strobes_off();
  endtask

  task automatic peek(input logic [2:0] sel, input logic [15:0] exp, input string tag);
    bus_sel = sel;
    #1;
    chk(tag, bus_o, exp);
  endtask

  // loads a word from the memory source; mask bits: 0 acc,1 dr,2 r1,3 r2,4 ir,5 pc
  task automatic put(input logic [5:0] mask, input logic [15:0] v);
    bus_sel = 3'd7; mem_rdata = v;
    ld_acc = mask[0]; ld_dr = mask[1]; ld_r1 = mask[2];
    ld_r2 = mask[3]; ld_ir = mask[4]; ld_pc = mask[5];
    tick();
  endtask

  task automatic t_reset();
    for (int s = 0; s < 6; s++) peek(3'(s), 16'h0000, "R1 reset register");
    chk("R1 reset mar", {4'h0, mem_addr}, 16'h0000);
  endtask

  task automatic t_mux();
    put(6'b000001, 16'h1111); put(6'b000010, 16'h2222); put(6'b000100, 16'h3333);
    put(6'b001000, 16'h4444); put(6'b010000, 16'h5A5B); put(6'b100000, 16'h6666);
    peek(3'd0, 16'h1111, "R2 acc src");
    peek(3'd1, 16'h2222, "R2 dr src");
    peek(3'd2, 16'h3333, "R2 r1 src");
    peek(3'd3, 16'h4444, "R2 r2 src");
    peek(3'd4, 16'h6666, "R2 pc src");
    peek(3'd5, 16'h5A5B, "R2 ir src");
    mem_rdata = 16'hABCD;
    peek(3'd7, 16'hABCD, "R2 mem src");
  endtask

  task automatic t_multi();
    put(6'b001100, 16'h0F0F);
    peek(3'd2, 16'h0F0F, "R9 r1 shared load");
    peek(3'd3, 16'h0F0F, "R9 r2 shared load");
  endtask

  task automatic t_hold();
    bus_sel = 3'd7; mem_rdata = 16'hDEAD; wr_req = 1; tick();
    peek(3'd0, 16'h1111, "R10 acc holds");
    peek(3'd1, 16'h2222, "R10 dr holds");
    peek(3'd2, 16'h0F0F, "R10 r1 holds");
    peek(3'd5, 16'h5A5B, "R10 ir holds");
  endtask

  task automatic t_add();
    put(6'b000001, 16'h7FFF); put(6'b000010, 16'h8002);
    alu_add = 1; peek(3'd6, 16'h0001, "R3 add wraps");
    ld_acc = 1; tick();
    peek(3'd0, 16'h0001, "R3 acc loaded sum");
  endtask

  task automatic t_and();
    put(6'b000001, 16'hF0F0); put(6'b000010, 16'h3C3C);
    alu_and = 1; peek(3'd6, 16'h3030, "R4 and");
    alu_and = 0; peek(3'd6, 16'h0000, "R5 no mode zero");
    alu_add = 1; alu_and = 1; peek(3'd6, 16'h2D2C, "R5 both gives add");
    strobes_off();
  endtask

  task automatic t_r1_path();
    put(6'b000001, 16'h0010); put(6'b000010, 16'h0001); put(6'b000100, 16'h0100);
    alu_add = 1; peek(3'd6, 16'h0011, "R11 r1 not an operand");
    alu_add = 0; bus_sel = 3'd2; ld_dr = 1; tick();
    alu_add = 1; peek(3'd6, 16'h0110, "R11 r1 via dr");
    strobes_off();
  endtask

  task automatic t_cpl();
    put(6'b000001, 16'h00FF);
    cpl_acc = 1; tick();
    peek(3'd0, 16'hFF00, "R6 complement");
    cpl_acc = 1; ld_acc = 1; bus_sel = 3'd7; mem_rdata = 16'h1234; tick();
    peek(3'd0, 16'h00FF, "R6 complement beats load");
  endtask

  task automatic t_mar();
    put(6'b010000, 16'hABCD);
    bus_sel = 3'd5; ld_mar = 1; tick();
    chk("R7 mar from ir", {4'h0, mem_addr}, 16'h0BCD);
    put(6'b100000, 16'h1234);
    bus_sel = 3'd4; ld_mar = 1; tick();
    chk("R7 mar from pc", {4'h0, mem_addr}, 16'h0234);
  endtask

  task automatic t_pc();
    put(6'b100000, 16'hFFFE);
    inc_pc = 1; tick();
    peek(3'd4, 16'hFFFF, "R8 pc inc");
    inc_pc = 1; tick();
    peek(3'd4, 16'h0000, "R8 pc wraps");
    inc_pc = 1; ld_pc = 1; bus_sel = 3'd7; mem_rdata = 16'h0400; tick();
    peek(3'd4, 16'h0400, "R8 load beats inc");
  endtask

  task automatic t_mem();
    mem_rdata = 16'hC0DE; bus_sel = 3'd7; wr_req = 1; #1;
    chk("R12 wdata is bus", mem_wdata, 16'hC0DE);
    chk("R12 we follows req", {15'h0, mem_we}, 16'h0001);
    wr_req = 0; bus_sel = 3'd4; #1;
    chk("R12 we low", {15'h0, mem_we}, 16'h0000);
    chk("R12 wdata tracks bus", mem_wdata, 16'h0400);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_mux();
    t_multi();
    t_hold();
    t_add();
    t_and();
    t_r1_path();
    t_cpl();
    t_mar();
    t_pc();
    t_mem();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule